// File: doc/BRIEF.md
# Debug Halt Control and Status Register

This block is the single halting-control register a debugger uses to stop, single-step and resume a small processor core. The debugger writes control requests over a 32-bit register bus. Each write must carry a 16-bit key in the upper half-word. The block turns the accepted requests into level outputs toward the core: debug enable, halt request, step request, interrupt mask and snap-stall.

On a read, the block returns the control bits together with live core status: halted, sleeping, the locked-up flag and the register-transfer-ready handshake. The read also returns three sticky event flags: instruction retired, reset seen and restart seen. Reading the register clears the three sticky flags.

A second bus address stands for the neighbouring core-register selector. A write to it only drops the transfer-ready flag, and the core's transfer-complete pulse raises the flag again. All core events arrive as single-cycle pulses. The core's halted and sleeping states arrive as levels.

Top module: `dbg_halt_ctl`

## Requirements
- R1: A write to the control address changes the control bits only when busWdata[31:16] equals 0xA05F. A write with any other upper half-word leaves every control bit as it was.
- R2: The control bits are stored at positions 0 (debug enable), 1 (halt), 2 (step), 3 (interrupt mask) and 5 (snap-stall), and they read back at the same positions. The outputs haltReq, stepReq, maskInts and snapStall each show their stored bit ANDed with debug enable, and debugEn shows bit 0.
- R3: A read returns the transfer-ready flag at bit 16, the coreHalted input at bit 17, the coreSleeping input at bit 18 and the locked-up flag at bit 19.
- R4: Bit 24 (retired) sets on a retire pulse while the core is not halted. Bit 25 (reset seen) sets on a core reset pulse. Bit 26 (restart) sets on a keyed write that clears halt while halt is 1. A read of the control address clears all three, except that an event in the same cycle as the read leaves its flag set.
- R5: A keyed write changes the interrupt-mask bit only when coreHalted is 1 and the same write sets bit 1. Otherwise the mask keeps its old value.
- R6: The locked-up flag sets on a lockup pulse and clears on any clock edge at which coreHalted is 1. The clear wins when both happen together.
- R7: The transfer-ready flag is 1 after reset. It clears on any write to the selector address and sets on a transfer-done pulse. The clear wins when both happen in the same cycle.
- R8: After reset, all control bits and sticky flags are 0, so a read returns 0x00010000 while the core inputs are idle.
- R9: While debug enable and step are 1 and halt is 0, one retire pulse sets the halt bit, so haltReq is 1 in the cycle after that pulse.
- R10: A read returns 0 at bit 4, bits 15:6 and bits 31:27. A read of any address other than the control address returns 0.
- R11: The read data is valid in the same cycle as busRd. The flags that read clears change at the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register word address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data, key in [31:16] |
| busRdata | output | 32 | Read data, valid with busRd |
| coreHalted | input | 1 | Core is in debug state (level) |
| coreSleeping | input | 1 | Core is sleeping (level) |
| coreLockupPulse | input | 1 | Core entered lockup (pulse) |
| coreRetirePulse | input | 1 | An instruction retired (pulse) |
| coreResetPulse | input | 1 | Core was reset (pulse) |
| xferDonePulse | input | 1 | Core-register transfer finished (pulse) |
| debugEn | output | 1 | Halting debug enabled |
| haltReq | output | 1 | Halt request to the core |
| stepReq | output | 1 | Single-step request to the core |
| maskInts | output | 1 | Interrupt mask request |
| snapStall | output | 1 | Imprecise-entry request |

## Verification
The key check is driven with the correct key, with keys that differ in one bit, with unrelated upper halves and with extra set bits in the reserved field. The pass-or-hold result then shows that the full 16 bits are compared, not just a few. The mask rule is tried with the core halted and running, and with the halt bit written as 1 and as 0, which tells the qualified update apart from a plain write. The sticky flags are read twice in a row and once in the same cycle as their event, which separates clear-on-read from a lost event. A step followed by a retire pulse shows the block raising halt again without any bus write.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int DATA_W = 32;
  localparam logic [15:0] WR_KEY = 16'hA05F;

  // control bit positions (read back at the same place)
  localparam int B_EN    = 0;
  localparam int B_HALT  = 1;
  localparam int B_STEP  = 2;
  localparam int B_MASK  = 3;
  localparam int B_SNAP  = 5;
  // status positions
  localparam int B_RDY   = 16;
  localparam int B_HLTD  = 17;
  localparam int B_SLP   = 18;
  localparam int B_LOCK  = 19;
  localparam int B_RET   = 24;
  localparam int B_RST   = 25;
  localparam int B_RSTRT = 26;

  typedef struct packed {
    logic ctlWr;     // keyed write to control address
    logic selWr;     // any write to selector address
    logic statRd;    // read of control address
    logic maskTake;  // mask bit may be updated by this write
  } ctlStrobes_t;
endpackage

// File: rtl/dbg_halt_dec.sv
module dbg_halt_dec
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int SEL_ADDR  = 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              coreHalted,
  output ctlStrobes_t       strb
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_ADDR);

  logic hitCtrl;
  logic hitSel;
  logic keyOk;

  always_comb begin
    hitCtrl       = (busAddr == CTRL_A);
    hitSel        = (busAddr == SEL_A);
    keyOk         = (busWdata[DATA_W-1:16] == WR_KEY);
    strb.ctlWr    = busWr & hitCtrl & keyOk;
    strb.selWr    = busWr & hitSel;
    strb.statRd   = busRd & hitCtrl;
    strb.maskTake = strb.ctlWr & coreHalted & busWdata[B_HALT];
  end
endmodule

// File: rtl/dbg_halt_regs.sv
module dbg_halt_regs
  import dbg_halt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              coreHalted,
  input  logic              coreSleeping,
  input  logic              coreLockupPulse,
  input  logic              coreRetirePulse,
  input  logic              coreResetPulse,
  input  logic              xferDonePulse,
  output logic [DATA_W-1:0] busRdata,
  output logic              debugEn,
  output logic              haltReq,
  output logic              stepReq,
  output logic              maskInts,
  output logic              snapStall
);
  logic enBit, haltBit, stepBit, maskBit, snapBit;
  logic rdyFlag, lockFlag;
  logic retSticky, rstSticky, restartSticky;
  logic stepDone;
  logic restartEvt;
  logic retEvt;
  logic [DATA_W-1:0] image;

  always_comb begin
    stepDone   = enBit & stepBit & ~haltBit & coreRetirePulse;
    restartEvt = strb.ctlWr & haltBit & ~busWdata[B_HALT];
    retEvt     = coreRetirePulse & ~coreHalted;
  end

  // control bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit   <= 1'b0;
      haltBit <= 1'b0;
      stepBit <= 1'b0;
      maskBit <= 1'b0;
      snapBit <= 1'b0;
    end else if (strb.ctlWr) begin
      enBit   <= busWdata[B_EN];
      haltBit <= busWdata[B_HALT];
      stepBit <= busWdata[B_STEP];
      snapBit <= busWdata[B_SNAP];
      if (strb.maskTake) maskBit <= busWdata[B_MASK];
    end else if (stepDone) begin
      haltBit <= 1'b1;
    end
  end

  // handshake and lockup flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdyFlag  <= 1'b1;
      lockFlag <= 1'b0;
    end else begin
      if (strb.selWr)        rdyFlag <= 1'b0;
      else if (xferDonePulse) rdyFlag <= 1'b1;
      if (coreHalted)           lockFlag <= 1'b0;
      else if (coreLockupPulse) lockFlag <= 1'b1;
    end
  end

  // sticky event flags, cleared by read unless an event arrives
  always_ff @(posedge clk) begin
    if (!rstN) begin
      retSticky     <= 1'b0;
      rstSticky     <= 1'b0;
      restartSticky <= 1'b0;
    end else begin
      if (retEvt)           retSticky <= 1'b1;
      else if (strb.statRd) retSticky <= 1'b0;
      if (coreResetPulse)   rstSticky <= 1'b1;
      else if (strb.statRd) rstSticky <= 1'b0;
      if (restartEvt)       restartSticky <= 1'b1;
      else if (strb.statRd) restartSticky <= 1'b0;
    end
  end

  always_comb begin
    image          = '0;
    image[B_EN]    = enBit;
    image[B_HALT]  = haltBit;
    image[B_STEP]  = stepBit;
    image[B_MASK]  = maskBit;
    image[B_SNAP]  = snapBit;
    image[B_RDY]   = rdyFlag;
    image[B_HLTD]  = coreHalted;
    image[B_SLP]   = coreSleeping;
    image[B_LOCK]  = lockFlag;
    image[B_RET]   = retSticky;
    image[B_RST]   = rstSticky;
    image[B_RSTRT] = restartSticky;
    busRdata       = strb.statRd ? image : '0;
    debugEn        = enBit;
    haltReq        = enBit & haltBit;
    stepReq        = enBit & stepBit;
    maskInts       = enBit & maskBit;
    snapStall      = enBit & snapBit;
  end
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int SEL_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              coreHalted,
  input  logic              coreSleeping,
  input  logic              coreLockupPulse,
  input  logic              coreRetirePulse,
  input  logic              coreResetPulse,
  input  logic              xferDonePulse,
  output logic              debugEn,
  output logic              haltReq,
  output logic              stepReq,
  output logic              maskInts,
  output logic              snapStall
);
  ctlStrobes_t strb;

  dbg_halt_dec #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .SEL_ADDR(SEL_ADDR)
  ) dec_i (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .coreHalted(coreHalted), .strb(strb)
  );

  dbg_halt_regs regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .coreHalted(coreHalted), .coreSleeping(coreSleeping),
    .coreLockupPulse(coreLockupPulse), .coreRetirePulse(coreRetirePulse),
    .coreResetPulse(coreResetPulse), .xferDonePulse(xferDonePulse),
    .busRdata(busRdata), .debugEn(debugEn), .haltReq(haltReq),
    .stepReq(stepReq), .maskInts(maskInts), .snapStall(snapStall)
  );
endmodule

// File: rtl/dbg_halt_chk.sv
module dbg_halt_chk #(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              coreHalted,
  input logic              coreRetirePulse,
  input logic              debugEn,
  input logic              haltReq,
  input logic              stepReq,
  input logic              maskInts
);
  logic ctrlHit;
  assign ctrlHit = (busAddr == ADDR_W'(CTRL_ADDR));

  AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && ctrlHit && busWdata[31:16] != 16'hA05F) |=> $stable(debugEn)); // R1

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && ctrlHit && busWdata[0] == debugEn && !(coreHalted && busWdata[1]))
      |=> $stable(maskInts)); // R5

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && ctrlHit) |-> (busRdata[15:6] == '0 && busRdata[31:27] == '0 && !busRdata[4])); // R10

  AST_HALT_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && ctrlHit) |-> (busRdata[17] == coreHalted)); // R3

  AST_LOCK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && ctrlHit && coreHalted && $past(coreHalted) && $past(rstN)) |-> !busRdata[19]); // R6

  AST_STEP_REHALT: assert property (@(posedge clk) disable iff (!rstN)
    (stepReq && !haltReq && coreRetirePulse && !busWr) |=> haltReq); // R9
endmodule

bind dbg_halt_ctl dbg_halt_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busWdata(busWdata), .busRdata(busRdata), .coreHalted(coreHalted),
  .coreRetirePulse(coreRetirePulse), .debugEn(debugEn), .haltReq(haltReq),
  .stepReq(stepReq), .maskInts(maskInts)
);

// File: tb/dbg_halt_ctl_tb_top.sv
module dbg_halt_ctl_tb_top;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEL  = 4'd1;
  localparam int NVEC = 11;
  // {write data, expected read after the write}, core idle, not halted
  localparam logic [63:0] VEC [NVEC] = '{
    {32'hA05F0001, 32'h00010001},  // R1 keyed enable
    {32'hA05F0003, 32'h00010003},  // R2 halt
    {32'h12340000, 32'h00010003},  // R1 wrong key
    {32'hA05F0001, 32'h04010001},  // R4 halt 1->0 restart
    {32'hA05F002B, 32'h00010023},  // R5 mask refused, R2 snap
    {32'hA05E0000, 32'h00010023},  // R1 one-bit key miss
    {32'hA05F0005, 32'h04010005},  // R4 restart with step
    {32'hA05F0000, 32'h00010000},  // R2 clear all
    {32'hFFFF0007, 32'h00010000},  // R1 bad key
    {32'hA05FFFC3, 32'h00010003},  // R10 reserved ignored
    {32'hA05F0013, 32'h00010003}   // R10 bit 4 ignored
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic coreHalted = 1'b0, coreSleeping = 1'b0;
  logic coreLockupPulse = 1'b0, coreRetirePulse = 1'b0, coreResetPulse = 1'b0;
  logic xferDonePulse = 1'b0;
  logic debugEn, haltReq, stepReq, maskInts, snapStall;

  int nChk = 0, nBad = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  dbg_halt_ctl #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .coreHalted(coreHalted),
    .coreSleeping(coreSleeping), .coreLockupPulse(coreLockupPulse),
    .coreRetirePulse(coreRetirePulse), .coreResetPulse(coreResetPulse),
    .xferDonePulse(xferDonePulse), .debugEn(debugEn), .haltReq(haltReq),
    .stepReq(stepReq), .maskInts(maskInts), .snapStall(snapStall)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  initial begin
    #400000;
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8 reset state
    check("R8 outputs", {27'd0, debugEn, haltReq, stepReq, maskInts, snapStall}, 32'd0);
    rdReg(A_CTRL, rv); check("R8 read", rv, 32'h00010000);

    for (int i = 0; i < NVEC; i++) begin
      wrReg(A_CTRL, VEC[i][63:32]);
      rdReg(A_CTRL, rv);
      check("R1/R2 table", rv, VEC[i][31:0]);
    end
    check("R2 outputs", {28'd0, debugEn, haltReq, stepReq, maskInts}, 32'b1100);

    // R5 mask qualification
    coreHalted = 1'b1;
    wrReg(A_CTRL, 32'hA05F0009);
    check("R5 halt=0 refused", {31'd0, maskInts}, 32'd0);
    rdReg(A_CTRL, rv); check("R5 read", rv, 32'h04030001);
    wrReg(A_CTRL, 32'hA05F000B);
    check("R5 accepted", {31'd0, maskInts}, 32'd1);
    coreHalted = 1'b0;
    wrReg(A_CTRL, 32'hA05F0003);
    check("R5 not halted keeps", {31'd0, maskInts}, 32'd1);
    rdReg(A_CTRL, rv); check("R5 read kept", rv, 32'h0001000B);
    coreHalted = 1'b1;
    wrReg(A_CTRL, 32'hA05F0003);
    rdReg(A_CTRL, rv); check("R5 cleared", rv, 32'h00030003);
    coreHalted = 1'b0;

    // R6 lockup
    @(negedge clk); coreLockupPulse = 1'b1; @(negedge clk); coreLockupPulse = 1'b0;
    rdReg(A_CTRL, rv); check("R6 lock set", rv, 32'h00090003);
    @(negedge clk); coreHalted = 1'b1;
    rdReg(A_CTRL, rv); check("R6 lock cleared", rv, 32'h00030003);
    coreHalted = 1'b0;

    // R7 transfer ready
    wrReg(A_SEL, 32'h00000005);
    rdReg(A_CTRL, rv); check("R7 cleared by select", rv, 32'h00000003);
    @(negedge clk); xferDonePulse = 1'b1; @(negedge clk); xferDonePulse = 1'b0;
    rdReg(A_CTRL, rv); check("R7 set by done", rv, 32'h00010003);
    @(negedge clk); busAddr = A_SEL; busWdata = 32'd0; busWr = 1'b1; xferDonePulse = 1'b1;
    @(negedge clk); busWr = 1'b0; xferDonePulse = 1'b0;
    rdReg(A_CTRL, rv); check("R7 clear wins", rv, 32'h00000003);
    @(negedge clk); xferDonePulse = 1'b1; @(negedge clk); xferDonePulse = 1'b0;

    // R4 sticky flags
    @(negedge clk); coreRetirePulse = 1'b1; @(negedge clk); coreRetirePulse = 1'b0;
    rdReg(A_CTRL, rv); check("R4 retire set", rv, 32'h01010003);
    rdReg(A_CTRL, rv); check("R4 retire cleared", rv, 32'h00010003);
    @(negedge clk); busAddr = A_CTRL; busRd = 1'b1; coreResetPulse = 1'b1;
    #1 rv = busRdata;
    @(negedge clk); busRd = 1'b0; coreResetPulse = 1'b0;
    check("R11 same-cycle read", rv, 32'h00010003);
    rdReg(A_CTRL, rv); check("R4 event during read kept", rv, 32'h02010003);
    rdReg(A_CTRL, rv); check("R4 reset cleared", rv, 32'h00010003);

    // R9 step then re-halt
    wrReg(A_CTRL, 32'hA05F0005);
    repeat (3) @(negedge clk);
    check("R9 released", {30'd0, haltReq, stepReq}, 32'b01);
    @(negedge clk); coreRetirePulse = 1'b1; @(negedge clk); coreRetirePulse = 1'b0;
    check("R9 re-halt", {31'd0, haltReq}, 32'd1);
    rdReg(A_CTRL, rv); check("R9 read", rv, 32'h05010007);

    // R10 other address, R2 enable gating
    rdReg(4'd2, rv); check("R10 other address", rv, 32'd0);
    wrReg(A_CTRL, 32'hA05F0002);
    check("R2 gated by enable", {31'd0, haltReq}, 32'd0);
    rdReg(A_CTRL, rv); check("R2 stored halt", rv, 32'h00010002);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule